// File: doc/BRIEF.md
# Processor Mode Bus Pin Controller

This block settles the operating mode of a 16-bit microcontroller and steers its external bus pins to suit that mode. A three-level strap pin is sampled once as reset ends. A strap at ground starts the part in single-chip mode, and software may then move it between single-chip, memory expansion and microprocessor modes. A strap at the supply rail starts it in microprocessor mode. A strap at twice the supply locks it into evaluation mode.

Once the mode is known, the block selects what each of two byte-wide ports carries. A port can carry general I/O, address, odd-byte data, even-byte data or both bytes of data. The choice follows the enable strobe level and a three-level bus-width pin. Each access is also given a bus width and a cycle type, with fixed overrides for two special register addresses and for the internal ROM range. Finally, the block gates the clock output pin and the enable pin according to a sleep indication, an output-disable bit and the pin's port direction and latch.

Pin levels arrive already digitised as 2-bit codes: 00 ground, 01 supply, 1x doubled supply.

Top module: `pmb_bus_ctl`

## Requirements
- R1: While reset is held, and until the strap is captured, the mode reads 00 and both lane selects read 0 (general I/O). The asynchronous reset is released through two synchronising flops, so the strap is captured on the third rising clock edge after rst_n rises. Strap changes after that edge have no effect until the next reset.
- R2: The mode encoding is 00 single-chip, 01 memory expansion, 10 microprocessor and 11 evaluation. A captured strap of 00 gives mode 00, a strap of 01 gives mode 10, and a strap of 10 or 11 gives mode 11.
- R3: A pulse on mode_wr loads mode_wdata into the mode on the next edge, but only when the strap was not doubled and the value is not 11. In every other case the write is ignored.
- R4: rom_en_o is 1 in modes 00 and 01, and 0 in modes 10 and 11.
- R5: Lane selects use the code 0 GPIO, 1 address, 2 odd data, 3 even data, 4 both bytes of data. They are recomputed only on a clock edge where ena_in differs from its value at the previous edge, and are held otherwise. The recomputation uses the mode in effect before that edge.
- R6: In mode 11, while the enable is high, both ports select address. While the enable is low, port 1 selects odd data, and port 2 selects even data if wid_lvl is 00 or both bytes if it is anything else.
- R7: In modes 01 and 10, while the enable is high, both ports select address. While the enable is low with wid_lvl 00, port 1 selects odd data and port 2 selects even data. While the enable is low with any other wid_lvl, port 1 selects address and port 2 selects both bytes. In mode 00, both ports select GPIO.
- R8: In mode 11, an access to address 0x0A or 0x0C is marked 16-bit (acc_wide_o=1) with internal cycle timing (acc_int_o=1), regardless of wid_lvl and wait_en.
- R9: When wid_lvl is doubled (bit 1 set), an access inside ROM_LO..ROM_HI is marked 16-bit, unless R8 applies.
- R10: Any other access is marked 16-bit exactly when wid_lvl is 00, and uses internal timing exactly when wait_en is 0. These flags register on an edge with acc_valid high and hold otherwise. They reset to 0.
- R11: clk_pin_o follows these rules. In mode 11 it carries cpu_clk. In mode 10 it carries clk_latch when out_dis and clk_dir are both 1, and cpu_clk otherwise. In mode 01 it carries clk_latch when out_dis and clk_dir are both 1, otherwise cpu_clk if clkout_en is set, otherwise clk_latch. In mode 00 it carries clk_latch.
- R12: ena_pin_o follows ena_in while sleep is 0. While sleep is 1, it drives 0 if out_dis is 1 and drives 1 if out_dis is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_lvl | input | 2 | Digitised mode strap level |
| wid_lvl | input | 2 | Digitised bus-width pin level |
| mode_wr | input | 1 | Software mode write strobe |
| mode_wdata | input | 2 | Software mode value |
| ena_in | input | 1 | Internal enable strobe level |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | ADDR_W | Access address |
| wait_en | input | 1 | Wait bit for external cycles |
| cpu_clk | input | 1 | Clock to present on the clock pin |
| clkout_en | input | 1 | Clock output selection bit |
| out_dis | input | 1 | Output-disable bit |
| clk_dir | input | 1 | Direction bit of the clock pin port |
| clk_latch | input | 1 | Port latch value of the clock pin |
| sleep | input | 1 | Wait or stop instruction in effect |
| mode_o | output | 2 | Current mode |
| rom_en_o | output | 1 | Internal ROM enabled |
| p1_sel_o | output | 3 | Port 1 lane select |
| p2_sel_o | output | 3 | Port 2 lane select |
| acc_wide_o | output | 1 | Access uses a 16-bit bus |
| acc_int_o | output | 1 | Access uses internal cycle timing |
| clk_pin_o | output | 1 | Clock output pin |
| ena_pin_o | output | 1 | Enable output pin |

## Verification
The bench goes after the strap capture edge: a design that sampled one cycle early or late, or kept sampling, would report the wrong mode once the strap moves after reset. It also writes 11 and writes while the mode is forced, which a careless mode register would accept. Enable levels held across several cycles while the mode or width pin changes catch lanes that switch without an enable edge, which would drive against external memory. Accesses to 0x0A, 0x0C and the ROM boundaries under every width level, together with every sleep, disable and direction combination, catch lost overrides and wrong pin gating.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

  typedef enum logic [1:0] {
    MODE_SOLO   = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_HOSTED = 2'b10,
    MODE_EVAL   = 2'b11
  } op_mode_e;

  typedef enum logic [2:0] {
    LANE_GPIO = 3'd0,
    LANE_ADDR = 3'd1,
    LANE_ODD  = 3'd2,
    LANE_EVEN = 3'd3,
    LANE_BOTH = 3'd4
  } lane_sel_e;

  localparam logic [1:0] LVL_LOW    = 2'b00;
  localparam logic [1:0] LVL_SUPPLY = 2'b01;

  function automatic logic lvl_doubled(input logic [1:0] lvl);
    return lvl[1];
  endfunction

endpackage

// File: rtl/pmb_mode_ctl.sv
module pmb_mode_ctl
  import pmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_lvl,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  output op_mode_e   mode_o,
  output logic       rom_en_o
);

  logic     done_q, done_d;
  logic     forced_q, forced_d;
  op_mode_e mode_q, mode_d;

  function automatic op_mode_e strap_to_mode(input logic [1:0] lvl);
    if (lvl_doubled(lvl))       return MODE_EVAL;
    else if (lvl == LVL_SUPPLY) return MODE_HOSTED;
    else                        return MODE_SOLO;
  endfunction

  always_comb begin
    done_d   = done_q;
    forced_d = forced_q;
    mode_d   = mode_q;
    if (!done_q) begin
      done_d   = 1'b1;
      forced_d = lvl_doubled(strap_lvl);
      mode_d   = strap_to_mode(strap_lvl);
    end else if (mode_wr && !forced_q && (mode_wdata != MODE_EVAL)) begin
      mode_d = op_mode_e'(mode_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      forced_q <= 1'b0;
      mode_q   <= MODE_SOLO;
    end else begin
      done_q   <= done_d;
      forced_q <= forced_d;
      mode_q   <= mode_d;
    end
  end

  assign mode_o   = mode_q;
  assign rom_en_o = (mode_q == MODE_SOLO) || (mode_q == MODE_EXPAND);

  p_forced_eval_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && forced_q) |-> (mode_q == MODE_EVAL));

  p_forced_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && forced_q && mode_wr) |=> $stable(mode_q));

  p_no_soft_eval_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !forced_q) |-> (mode_q != MODE_EVAL));

endmodule

// File: rtl/pmb_lane_steer.sv
module pmb_lane_steer
  import pmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_mode_e   mode_i,
  input  logic       ena_i,
  input  logic [1:0] wid_lvl_i,
  output lane_sel_e  p1_sel_o,
  output lane_sel_e  p2_sel_o
);

  logic      ena_q;
  logic      ena_edge;
  lane_sel_e p1_q, p1_d, p2_q, p2_d;
  lane_sel_e p1_tgt, p2_tgt;

  assign ena_edge = ena_i ^ ena_q;

  always_comb begin
    p1_tgt = LANE_GPIO;
    p2_tgt = LANE_GPIO;
    unique case (mode_i)
      MODE_EVAL: begin
        if (ena_i) begin
          p1_tgt = LANE_ADDR;
          p2_tgt = LANE_ADDR;
        end else begin
          p1_tgt = LANE_ODD;
          p2_tgt = (wid_lvl_i == LVL_LOW) ? LANE_EVEN : LANE_BOTH;
        end
      end
      MODE_EXPAND, MODE_HOSTED: begin
        if (ena_i) begin
          p1_tgt = LANE_ADDR;
          p2_tgt = LANE_ADDR;
        end else if (wid_lvl_i == LVL_LOW) begin
          p1_tgt = LANE_ODD;
          p2_tgt = LANE_EVEN;
        end else begin
          p1_tgt = LANE_ADDR;
          p2_tgt = LANE_BOTH;
        end
      end
      default: begin
        p1_tgt = LANE_GPIO;
        p2_tgt = LANE_GPIO;
      end
    endcase
  end

  always_comb begin
    p1_d = p1_q;
    p2_d = p2_q;
    if (ena_edge) begin
      p1_d = p1_tgt;
      p2_d = p2_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= 1'b0;
      p1_q  <= LANE_GPIO;
      p2_q  <= LANE_GPIO;
    end else begin
      ena_q <= ena_i;
      p1_q  <= p1_d;
      p2_q  <= p2_d;
    end
  end

  assign p1_sel_o = p1_q;
  assign p2_sel_o = p2_q;

  p_lane_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_i == ena_q) |=> ($stable(p1_q) && $stable(p2_q)));

  p_eval_addr_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_edge && ena_i && mode_i == MODE_EVAL) |=> (p1_q == LANE_ADDR && p2_q == LANE_ADDR));

  p_solo_gpio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_edge && mode_i == MODE_SOLO) |=> (p1_q == LANE_GPIO && p2_q == LANE_GPIO));

endmodule

// File: rtl/pmb_acc_class.sv
module pmb_acc_class
  import pmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] REG_A_ADDR = 'h0A,
  parameter logic [ADDR_W-1:0] REG_B_ADDR = 'h0C,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_mode_e          mode_i,
  input  logic [1:0]        wid_lvl_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wait_en_i,
  output logic              wide_o,
  output logic              int_o
);

  logic reg_hit, rom_hit;
  logic wide_c, int_c;
  logic wide_q, wide_d, int_q, int_d;

  assign reg_hit = (addr_i == REG_A_ADDR) || (addr_i == REG_B_ADDR);
  assign rom_hit = (addr_i >= ROM_LO) && (addr_i <= ROM_HI);

  always_comb begin
    if (mode_i == MODE_EVAL && reg_hit) begin
      wide_c = 1'b1;
      int_c  = 1'b1;
    end else begin
      wide_c = (wid_lvl_i == LVL_LOW) || (lvl_doubled(wid_lvl_i) && rom_hit);
      int_c  = !wait_en_i;
    end
  end

  always_comb begin
    wide_d = wide_q;
    int_d  = int_q;
    if (valid_i) begin
      wide_d = wide_c;
      int_d  = int_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      wide_q <= wide_d;
      int_q  <= int_d;
    end
  end

  assign wide_o = wide_q;
  assign int_o  = int_q;

  p_reg_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i == MODE_EVAL && reg_hit) |=> (wide_q && int_q));

  p_rom_wide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && lvl_doubled(wid_lvl_i) && rom_hit) |=> wide_q);

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(wide_q) && $stable(int_q)));

endmodule

// File: rtl/pmb_pin_gate.sv
module pmb_pin_gate
  import pmb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode_i,
  input  logic     ena_i,
  input  logic     cpu_clk_i,
  input  logic     clkout_en_i,
  input  logic     out_dis_i,
  input  logic     clk_dir_i,
  input  logic     clk_latch_i,
  input  logic     sleep_i,
  output logic     clk_pin_o,
  output logic     ena_pin_o
);

  logic park_clk;

  assign park_clk = out_dis_i && clk_dir_i;

  always_comb begin
    unique case (mode_i)
      MODE_EVAL:   clk_pin_o = cpu_clk_i;
      MODE_HOSTED: clk_pin_o = park_clk ? clk_latch_i : cpu_clk_i;
      MODE_EXPAND: clk_pin_o = park_clk ? clk_latch_i
                               : (clkout_en_i ? cpu_clk_i : clk_latch_i);
      default:     clk_pin_o = clk_latch_i;
    endcase
  end

  always_comb begin
    if (sleep_i) ena_pin_o = !out_dis_i;
    else         ena_pin_o = ena_i;
  end

  p_sleep_ena_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && out_dis_i) |-> !ena_pin_o);

  p_sleep_ena_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !out_dis_i) |-> ena_pin_o);

  p_eval_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_EVAL) |-> (clk_pin_o == cpu_clk_i));

endmodule

// File: rtl/pmb_bus_ctl.sv
module pmb_bus_ctl
  import pmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter logic [ADDR_W-1:0] ROM_LO = 'h8000,
  parameter logic [ADDR_W-1:0] ROM_HI = 'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_lvl,
  input  logic [1:0]        wid_lvl,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              ena_in,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wait_en,
  input  logic              cpu_clk,
  input  logic              clkout_en,
  input  logic              out_dis,
  input  logic              clk_dir,
  input  logic              clk_latch,
  input  logic              sleep,
  output logic [1:0]        mode_o,
  output logic              rom_en_o,
  output logic [2:0]        p1_sel_o,
  output logic [2:0]        p2_sel_o,
  output logic              acc_wide_o,
  output logic              acc_int_o,
  output logic              clk_pin_o,
  output logic              ena_pin_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   srst_n;
  op_mode_e               mode;
  lane_sel_e              p1_sel, p2_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign srst_n = rst_sync_q[SYNC_STAGES-1];

  pmb_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (srst_n),
    .strap_lvl  (strap_lvl),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_o     (mode),
    .rom_en_o   (rom_en_o)
  );

  pmb_lane_steer u_lanes (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode_i    (mode),
    .ena_i     (ena_in),
    .wid_lvl_i (wid_lvl),
    .p1_sel_o  (p1_sel),
    .p2_sel_o  (p2_sel)
  );

  pmb_acc_class #(
    .ADDR_W (ADDR_W),
    .ROM_LO (ROM_LO),
    .ROM_HI (ROM_HI)
  ) u_acc (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode_i    (mode),
    .wid_lvl_i (wid_lvl),
    .valid_i   (acc_valid),
    .addr_i    (acc_addr),
    .wait_en_i (wait_en),
    .wide_o    (acc_wide_o),
    .int_o     (acc_int_o)
  );

  pmb_pin_gate u_pins (
    .clk         (clk),
    .rst_n       (srst_n),
    .mode_i      (mode),
    .ena_i       (ena_in),
    .cpu_clk_i   (cpu_clk),
    .clkout_en_i (clkout_en),
    .out_dis_i   (out_dis),
    .clk_dir_i   (clk_dir),
    .clk_latch_i (clk_latch),
    .sleep_i     (sleep),
    .clk_pin_o   (clk_pin_o),
    .ena_pin_o   (ena_pin_o)
  );

  assign mode_o   = mode;
  assign p1_sel_o = p1_sel;
  assign p2_sel_o = p2_sel;

  p_rom_off_hosted_r4: assert property (@(posedge clk) disable iff (!srst_n)
    mode_o[1] |-> !rom_en_o);

endmodule

// File: tb/pmb_bus_ctl_tb_top.sv
module pmb_bus_ctl_tb_top;

  localparam int AW = 24;
  localparam logic [AW-1:0] ROM_LO = 24'h8000;
  localparam logic [AW-1:0] ROM_HI = 24'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] strap_lvl = 2'b00, wid_lvl = 2'b00, mode_wdata = 2'b00;
  logic mode_wr = 0, ena_in = 0, acc_valid = 0, wait_en = 0, cpu_clk = 0;
  logic clkout_en = 0, out_dis = 0, clk_dir = 0, clk_latch = 0, sleep = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] mode_o;
  logic rom_en_o, acc_wide_o, acc_int_o, clk_pin_o, ena_pin_o;
  logic [2:0] p1_sel_o, p2_sel_o;

  always #10 clk = ~clk;

  pmb_bus_ctl #(.ADDR_W(AW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string mode_tag = "R2";

  // reference model state
  int since_rel = 0;
  int m_mode = 0, m_p1 = 0, m_p2 = 0;
  bit m_done = 0, m_forced = 0, m_enaq = 0, m_wide = 0, m_int = 0;
  string m_sel_tag = "R1", m_acc_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge rst_n) begin
    since_rel = 0; m_done = 0; m_forced = 0; m_mode = 0;
    m_enaq = 0; m_p1 = 0; m_p2 = 0; m_wide = 0; m_int = 0;
    m_sel_tag = "R1"; m_acc_tag = "R1";
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (since_rel >= 2) begin
        int om;
        om = m_mode;
        if (!m_done) begin
          m_done = 1;
          m_forced = strap_lvl[1];
          m_mode = strap_lvl[1] ? 3 : (strap_lvl == 2'b01 ? 2 : 0);
        end else if (mode_wr && !m_forced && mode_wdata != 2'b11) begin
          m_mode = int'(mode_wdata);
        end
        if (ena_in != m_enaq) begin
          if (om == 0) begin m_p1 = 0; m_p2 = 0; end
          else if (ena_in) begin m_p1 = 1; m_p2 = 1; end
          else if (om == 3) begin m_p1 = 2; m_p2 = (wid_lvl == 0) ? 3 : 4; end
          else if (wid_lvl == 0) begin m_p1 = 2; m_p2 = 3; end
          else begin m_p1 = 1; m_p2 = 4; end
          m_sel_tag = (om == 3) ? "R6" : "R7";
        end else begin
          m_sel_tag = "R5";
        end
        m_enaq = ena_in;
        if (acc_valid) begin
          if (om == 3 && (acc_addr == 24'h0A || acc_addr == 24'h0C)) begin
            m_wide = 1; m_int = 1; m_acc_tag = "R8";
          end else begin
            bit inrom;
            inrom = (acc_addr >= ROM_LO) && (acc_addr <= ROM_HI);
            m_wide = (wid_lvl == 0) || (wid_lvl[1] && inrom);
            m_int = !wait_en;
            m_acc_tag = (wid_lvl[1] && inrom) ? "R9" : "R10";
          end
        end else begin
          m_acc_tag = "R10";
        end
      end
      if (since_rel < 1000) since_rel++;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      int ck;
      string mt;
      mt = (since_rel < 3) ? "R1" : mode_tag;
      chk(mt, "mode", int'(mode_o), m_mode);
      chk("R4", "rom_en", int'(rom_en_o), (m_mode < 2) ? 1 : 0);
      chk(m_sel_tag, "p1_sel", int'(p1_sel_o), m_p1);
      chk(m_sel_tag, "p2_sel", int'(p2_sel_o), m_p2);
      chk(m_acc_tag, "acc_wide", int'(acc_wide_o), int'(m_wide));
      chk(m_acc_tag, "acc_int", int'(acc_int_o), int'(m_int));
      case (m_mode)
        3: ck = cpu_clk;
        2: ck = (out_dis && clk_dir) ? clk_latch : cpu_clk;
        1: ck = (out_dis && clk_dir) ? clk_latch : (clkout_en ? cpu_clk : clk_latch);
        default: ck = clk_latch;
      endcase
      chk("R11", "clk_pin", int'(clk_pin_o), ck);
      chk("R12", "ena_pin", int'(ena_pin_o), sleep ? int'(!out_dis) : int'(ena_in));
    end
  end

  task automatic do_reset(input logic [1:0] s);
    @(posedge clk); #5;
    rst_n = 0; strap_lvl = s; mode_wr = 0; acc_valid = 0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (4) @(posedge clk);
    #5;
  endtask

  task automatic sw_write(input logic [1:0] v);
    @(posedge clk); #5;
    mode_wr = 1; mode_wdata = v;
    @(posedge clk); #5;
    mode_wr = 0;
    @(posedge clk); #5;
  endtask

  task automatic exercise(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if ($urandom % 3 == 0) ena_in = ~ena_in;
      wid_lvl   = 2'($urandom);
      strap_lvl = 2'($urandom);
      acc_valid = ($urandom % 4) != 0;
      case ($urandom % 7)
        0: acc_addr = 24'h00000A;
        1: acc_addr = 24'h00000C;
        2: acc_addr = ROM_LO;
        3: acc_addr = ROM_HI;
        4: acc_addr = ROM_HI + 24'd1;
        5: acc_addr = ROM_LO - 24'd1;
        default: acc_addr = 24'($urandom);
      endcase
      wait_en   = 1'($urandom);
      cpu_clk   = 1'($urandom);
      clkout_en = 1'($urandom);
      out_dis   = 1'($urandom);
      clk_dir   = 1'($urandom);
      clk_latch = 1'($urandom);
      sleep     = ($urandom % 4) == 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1/R2: ground strap, single-chip start
    do_reset(2'b00);
    exercise(200);
    mode_tag = "R3";
    sw_write(2'b11);      // R3: ignored
    sw_write(2'b01);      // R3: expansion
    exercise(300);
    sw_write(2'b10);      // R3: microprocessor
    exercise(300);
    sw_write(2'b11);      // R3: ignored
    sw_write(2'b00);
    exercise(150);
    mode_tag = "R2";
    // R2: supply strap, microprocessor start
    do_reset(2'b01);
    exercise(300);
    mode_tag = "R3";
    sw_write(2'b01);
    exercise(200);
    mode_tag = "R2";
    // R2/R6/R8/R9: doubled strap, forced evaluation
    do_reset(2'b10);
    exercise(500);
    mode_tag = "R3";
    sw_write(2'b01);      // R3: ignored when forced
    sw_write(2'b00);
    exercise(100);
    mode_tag = "R2";
    do_reset(2'b11);
    exercise(300);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule